// File: doc/BRIEF.md
# Oscillator Clock Supervisor

This block watches an external oscillator clock from a separate, always-running reference clock. It has two parts. A coarse timeout monitor counts reference cycles between oscillator rising edges. When an edge fails to arrive in time, it raises a failure. A quality checker then counts oscillator edges over a fixed window of reference cycles, and the oscillator is accepted only when enough edges are seen.

Four events start a quality check: a power-on reset event, a low-voltage reset event, a wake-up from full stop, and a monitor failure. A mode input selects what a monitor failure causes. With the mode input set, the failure requests the fallback self-clocked mode, and a later passing check withdraws that request. With the mode input clear, the failure requests a system reset, and the request stays asserted until the block itself is reset. Oscillator edges reach the reference domain through a two-flop synchronizer followed by a rising-edge detector. All outputs are registered in the reference domain.

Top module: `osc_supervisor`

## Requirements
- R1: With `mon_en` high, when no oscillator rising edge is detected for `TIMEOUT_CYC` reference cycles, `mon_fail` goes high. Detection adds a synchronizer latency of about three reference cycles.
- R2: When a monitor failure occurs while `scm_en` is 1, `scm_req` goes high on the same cycle as `mon_fail` and `rst_req` stays low.
- R3: When a monitor failure occurs while `scm_en` is 0, `rst_req` goes high and `scm_req` stays low. Once high, `rst_req` stays high until `rst_n` is asserted.
- R4: While `mon_en` is 0, `mon_fail`, `scm_req` and `rst_req` stay low even when the oscillator is stopped.
- R5: While the oscillator keeps toggling with a period shorter than `TIMEOUT_CYC` reference cycles, no failure is reported.
- R6: Each of the four trigger sources starts a quality check: `por_evt`, `lvr_evt`, `stop_wake_evt` and an internal monitor failure. `check_done` is low from the reference edge after the trigger.
- R7: `check_done` rises exactly `WINDOW_CYC` reference edges after the edge that sampled the trigger, provided at least `MIN_EDGES` oscillator rising edges were counted in the window.
- R8: If fewer than `MIN_EDGES` oscillator rising edges are counted in the window, `check_done` stays low when the window ends.
- R9: A passing quality check clears `scm_req` and `mon_fail`.
- R10: A trigger that arrives during an active window restarts it. The result is then due `WINDOW_CYC` edges after the new trigger, and nothing is reported at the end of the old window.
- R11: While `rst_n` is low, and right after it is released, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock (PLL at its minimum rate); all logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk | input | 1 | Supervised oscillator clock, asynchronous to `ref_clk` |
| mon_en | input | 1 | Enables the timeout monitor |
| scm_en | input | 1 | 1: a failure requests self-clocked mode; 0: a failure requests a reset |
| por_evt | input | 1 | Power-on reset event pulse; starts a check |
| lvr_evt | input | 1 | Low-voltage reset event pulse; starts a check |
| stop_wake_evt | input | 1 | Wake from full stop event pulse; starts a check |
| mon_fail | output | 1 | Monitor failure flag |
| scm_req | output | 1 | Self-clocked mode request |
| rst_req | output | 1 | System reset request |
| check_done | output | 1 | Last quality check passed |

## Verification
A trigger sampled on one reference edge clears `check_done` by the next sample point. On a pass, `check_done` rises exactly `WINDOW_CYC` edges after the trigger. The bench counts negative edges from the trigger and samples one cycle before and exactly at that edge, both for a single trigger and for a restarted window. A failure appears `TIMEOUT_CYC` plus the synchronizer delay after the last oscillator edge. Because the oscillator is asynchronous, the bench brackets that point with a few cycles of margin on each side. Results that clear on a passing check are sampled well after the window has ended.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;
   localparam int unsigned DEF_WINDOW_CYC  = 50000;
   localparam int unsigned DEF_TIMEOUT_CYC = 64;
   localparam int unsigned DEF_MIN_EDGES   = 1024;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   typedef enum logic {
      QC_IDLE = 1'b0,
      QC_RUN  = 1'b1
   } qc_state_e;
endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic osc_clk,
   output logic osc_rise
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge ref_clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= osc_clk;
            end
         end else begin : g_next
            always_ff @(posedge ref_clk or negedge rst_n) begin
               if (!rst_n) sync_q[i] <= 1'b0;
               else        sync_q[i] <= sync_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign osc_rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/osc_timeout_mon.sv
module osc_timeout_mon #(
   parameter int unsigned TIMEOUT_CYC = 64
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic enable,
   input  logic osc_rise,
   output logic fail_evt
);
   localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
   localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYC - 1);
   localparam logic [TW-1:0] HOLD = TW'(TIMEOUT_CYC);

   logic [TW-1:0] gap_q;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q    <= '0;
         fail_evt <= 1'b0;
      end else begin
         fail_evt <= 1'b0;
         if (!enable || osc_rise) begin
            gap_q <= '0;
         end else if (gap_q == LAST) begin
            gap_q    <= HOLD;
            fail_evt <= 1'b1;
         end else if (gap_q != HOLD) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/osc_quality_chk.sv
module osc_quality_chk
   import osc_sup_pkg::*;
#(
   parameter int unsigned WINDOW_CYC = 50000,
   parameter int unsigned MIN_EDGES  = 1024
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic trig,
   input  logic osc_rise,
   output logic done,
   output logic pass_evt
);
   localparam int unsigned WW = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;
   localparam int unsigned EW = $clog2(MIN_EDGES + 1);
   localparam logic [WW-1:0] WLAST = WW'(WINDOW_CYC - 1);
   localparam logic [EW-1:0] ENEED = EW'(MIN_EDGES);

   qc_state_e     state_q;
   logic [WW-1:0] win_q;
   logic [EW-1:0] edges_q;
   logic [EW-1:0] edges_nx;

   always_comb begin
      edges_nx = edges_q;
      if (osc_rise && edges_q != ENEED) edges_nx = edges_q + 1'b1;
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= QC_IDLE;
         win_q    <= '0;
         edges_q  <= '0;
         done     <= 1'b0;
         pass_evt <= 1'b0;
      end else begin
         pass_evt <= 1'b0;
         if (trig) begin
            state_q <= QC_RUN;
            win_q   <= '0;
            edges_q <= '0;
            done    <= 1'b0;
         end else if (state_q == QC_RUN) begin
            edges_q <= edges_nx;
            if (win_q == WLAST) begin
               state_q <= QC_IDLE;
               if (edges_nx == ENEED) begin
                  done     <= 1'b1;
                  pass_evt <= 1'b1;
               end
            end else begin
               win_q <= win_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/osc_supervisor.sv
module osc_supervisor
   import osc_sup_pkg::*;
#(
   parameter int unsigned TIMEOUT_CYC = DEF_TIMEOUT_CYC,
   parameter int unsigned WINDOW_CYC  = DEF_WINDOW_CYC,
   parameter int unsigned MIN_EDGES   = DEF_MIN_EDGES,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic osc_clk,
   input  logic mon_en,
   input  logic scm_en,
   input  logic por_evt,
   input  logic lvr_evt,
   input  logic stop_wake_evt,
   output logic mon_fail,
   output logic scm_req,
   output logic rst_req,
   output logic check_done
);
   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_timeout
         $error("TIMEOUT_CYC must be at least 2");
      end
      if (WINDOW_CYC < 2) begin : g_bad_window
         $error("WINDOW_CYC must be at least 2");
      end
      if (MIN_EDGES < 1 || MIN_EDGES > WINDOW_CYC) begin : g_bad_edges
         $error("MIN_EDGES must lie in 1..WINDOW_CYC");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic osc_rise;
   logic fail_evt;
   logic pass_evt;
   logic qc_trig;
   logic fail_ok;

   osc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .osc_clk (osc_clk),
      .osc_rise(osc_rise)
   );

   osc_timeout_mon #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_mon (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .enable  (mon_en),
      .osc_rise(osc_rise),
      .fail_evt(fail_evt)
   );

   assign fail_ok = fail_evt & mon_en;
   assign qc_trig = por_evt | lvr_evt | stop_wake_evt | fail_ok;

   osc_quality_chk #(.WINDOW_CYC(WINDOW_CYC), .MIN_EDGES(MIN_EDGES)) u_qc (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .trig    (qc_trig),
      .osc_rise(osc_rise),
      .done    (check_done),
      .pass_evt(pass_evt)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         mon_fail <= 1'b0;
         scm_req  <= 1'b0;
         rst_req  <= 1'b0;
      end else begin
         mon_fail <= mon_en & (fail_evt | (mon_fail & ~pass_evt));
         scm_req  <= (fail_ok & scm_en) | (scm_req & ~pass_evt);
         rst_req  <= (fail_ok & ~scm_en) | rst_req;
      end
   end
endmodule

// File: rtl/osc_supervisor_chk.sv
module osc_supervisor_chk (
   input logic ref_clk,
   input logic rst_n,
   input logic mon_en,
   input logic scm_en,
   input logic por_evt,
   input logic lvr_evt,
   input logic stop_wake_evt,
   input logic mon_fail,
   input logic scm_req,
   input logic rst_req,
   input logic check_done,
   input logic fail_evt,
   input logic pass_evt
);
   assert_fail_needs_en_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(mon_fail) |-> $past(mon_en));

   assert_scm_mode_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(scm_req) |-> $past(scm_en));

   assert_rst_sticky_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      rst_req |=> rst_req);

   assert_rst_mode_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
      $rose(rst_req) |-> !$past(scm_en));

   assert_disabled_quiet_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !mon_en |=> !mon_fail);

   assert_trig_clears_done_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (por_evt || lvr_evt || stop_wake_evt) |=> !check_done);

   assert_pass_clears_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (pass_evt && !fail_evt) |=> (!scm_req && !mon_fail));
endmodule

bind osc_supervisor osc_supervisor_chk u_chk (
   .ref_clk      (ref_clk),
   .rst_n        (rst_n),
   .mon_en       (mon_en),
   .scm_en       (scm_en),
   .por_evt      (por_evt),
   .lvr_evt      (lvr_evt),
   .stop_wake_evt(stop_wake_evt),
   .mon_fail     (mon_fail),
   .scm_req      (scm_req),
   .rst_req      (rst_req),
   .check_done   (check_done),
   .fail_evt     (fail_evt),
   .pass_evt     (pass_evt)
);

// File: tb/osc_supervisor_tb_top.sv
module osc_supervisor_tb_top;
   localparam int TO  = 32;
   localparam int W   = 200;
   localparam int MIN = 20;

   logic ref_clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc_clk = 1'b0;
   logic mon_en = 1'b0, scm_en = 1'b0;
   logic por_evt = 1'b0, lvr_evt = 1'b0, stop_wake_evt = 1'b0;
   logic mon_fail, scm_req, rst_req, check_done;

   int  n_chk = 0, n_fail = 0;
   bit  osc_run = 1'b1;
   int  osc_half = 50;
   bit  finished = 1'b0;

   always #10 ref_clk = ~ref_clk;

   initial begin
      #5;
      forever begin
         #(osc_half);
         if (osc_run || osc_clk) osc_clk = ~osc_clk;
      end
   end

   osc_supervisor #(.TIMEOUT_CYC(TO), .WINDOW_CYC(W), .MIN_EDGES(MIN), .SYNC_STAGES(2)) dut_i (
      .ref_clk(ref_clk), .rst_n(rst_n), .osc_clk(osc_clk),
      .mon_en(mon_en), .scm_en(scm_en),
      .por_evt(por_evt), .lvr_evt(lvr_evt), .stop_wake_evt(stop_wake_evt),
      .mon_fail(mon_fail), .scm_req(scm_req), .rst_req(rst_req), .check_done(check_done)
   );

   task automatic chk(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic reset_dut();
      @(negedge ref_clk);
      rst_n = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
   endtask

   // 0: por, 1: lvr, 2: wake; returns just after the sampling edge
   task automatic pulse(int which);
      @(negedge ref_clk);
      if (which == 0) por_evt = 1'b1;
      else if (which == 1) lvr_evt = 1'b1;
      else stop_wake_evt = 1'b1;
      @(negedge ref_clk);
      por_evt = 1'b0; lvr_evt = 1'b0; stop_wake_evt = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge ref_clk);
      chk("R11 mon_fail in reset", mon_fail, 1'b0);
      chk("R11 scm_req in reset", scm_req, 1'b0);
      reset_dut();
      chk("R11 rst_req after reset", rst_req, 1'b0);
      chk("R11 check_done after reset", check_done, 1'b0);
   endtask

   task automatic t_por_pass();
      pulse(0);
      chk("R6 por starts check", check_done, 1'b0);
      wait_cyc(W - 1);
      chk("R7 done not before window end", check_done, 1'b0);
      wait_cyc(1);
      chk("R7 done at window end", check_done, 1'b1);
   endtask

   task automatic t_retrigger();
      pulse(2);
      chk("R6 wake clears done", check_done, 1'b0);
      wait_cyc(100);
      pulse(0);
      wait_cyc(W - 102);
      chk("R10 old window end ignored", check_done, 1'b0);
      wait_cyc(101);
      chk("R10 not before new window end", check_done, 1'b0);
      wait_cyc(1);
      chk("R10 done at new window end", check_done, 1'b1);
   endtask

   task automatic t_quality_fail();
      osc_half = 300;
      pulse(1);
      chk("R6 lvr clears done", check_done, 1'b0);
      wait_cyc(W + 5);
      chk("R8 too few edges", check_done, 1'b0);
      osc_half = 50;
      wait_cyc(20);
   endtask

   task automatic t_disabled();
      mon_en = 1'b0;
      osc_run = 1'b0;
      wait_cyc(3 * TO);
      chk("R4 no fail when disabled", mon_fail, 1'b0);
      chk("R4 no scm_req when disabled", scm_req, 1'b0);
      chk("R4 no rst_req when disabled", rst_req, 1'b0);
      osc_run = 1'b1;
      wait_cyc(10);
   endtask

   task automatic t_running_ok();
      mon_en = 1'b1;
      wait_cyc(5 * TO);
      chk("R5 no fail with toggling osc", mon_fail, 1'b0);
      chk("R5 no rst_req with toggling osc", rst_req, 1'b0);
   endtask

   task automatic t_fail_scm();
      scm_en = 1'b1;
      @(negedge ref_clk);
      osc_run = 1'b0;
      wait_cyc(TO - 6);
      chk("R1 no fail before timeout", mon_fail, 1'b0);
      wait_cyc(14);
      chk("R1 fail after timeout", mon_fail, 1'b1);
      chk("R2 scm_req on fail", scm_req, 1'b1);
      chk("R2 no rst_req in scm mode", rst_req, 1'b0);
      chk("R6 monitor fail starts check", check_done, 1'b0);
      osc_run = 1'b1;
      wait_cyc(W + 20);
      chk("R9 pass clears scm_req", scm_req, 1'b0);
      chk("R9 pass clears mon_fail", mon_fail, 1'b0);
      chk("R7 check passes after recovery", check_done, 1'b1);
   endtask

   task automatic t_fail_rst();
      scm_en = 1'b0;
      @(negedge ref_clk);
      osc_run = 1'b0;
      wait_cyc(TO + 8);
      chk("R3 rst_req on fail", rst_req, 1'b1);
      chk("R3 no scm_req in reset mode", scm_req, 1'b0);
      osc_run = 1'b1;
      wait_cyc(W + 20);
      chk("R3 rst_req held after pass", rst_req, 1'b1);
      reset_dut();
      chk("R3 rst_req cleared by reset", rst_req, 1'b0);
   endtask

   initial begin
      t_reset();
      t_por_pass();
      t_retrigger();
      t_quality_fail();
      t_disabled();
      t_running_ok();
      t_fail_scm();
      t_fail_rst();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge ref_clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=expired expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule